// File: doc/BRIEF.md
# Clock-Edge Counting Shift Unit

This block is the byte engine for a two-wire bus slave. An 8-bit data register takes in one bit from the data line on each rising edge of the bus clock. A 4-bit edge counter advances on every clock-line transition, whether rising or falling. One byte therefore takes sixteen edges. When the counter wraps from its top value back to zero, a sticky overflow flag is raised. While that flag stands, the block asks for the clock line to be held low, which stretches the bus until software has dealt with the byte.

Software works the unit through plain load strobes and a flag clear. It can load the data register to send a byte, or to set up an acknowledge. It can preload the counter, and a preload of 14 lets exactly one bit slot through before the clock is held again. A transmit enable decides whether the unit may pull the data line low at all. When the enable is set, the pull follows the complement of the register's top bit. Both bus inputs are expected to be synchronised to the system clock already. Address matching is left to software. The bus inputs and register ports are plain signals sampled on every clock, so the unit applies no back-pressure of its own. The only flow control it exerts is the clock-line hold.

Top module: `edge_count_shifter`

## Requirements
- R1: After reset the data register reads 0x00, the counter reads 0, and the overflow flag, the clock hold and the data-line pull are all 0.
- R2: On a rising edge of `scl_i` the data register shifts one place toward its MSB, and `sda_i` enters at bit 0. The new value is visible one clock after the edge is seen.
- R3: A falling edge of `scl_i` leaves the data register unchanged.
- R4: Every edge of `scl_i`, rising or falling, adds one to the counter.
- R5: An edge that finds the counter at 15 wraps it to 0 and sets the overflow flag. The flag then stays set, even with no further edges, until it is cleared.
- R6: `scl_hold` is 1 exactly while the overflow flag is set. A pulse on `ovf_clr` clears the flag and releases the hold one clock later.
- R7: `data_ld` loads `data_ld_val` into the data register. The load takes priority over a shift in the same clock.
- R8: `cnt_ld` loads `cnt_ld_val` into the counter, and this takes priority over counting in the same clock. After a preload of 14, one falling edge gives 15 with no overflow, and the following rising edge gives 0 with overflow set.
- R9: `sda_pull_low` is 1 only when `tx_en` is 1 and bit 7 of the data register is 0. A 1 in bit 7, or `tx_en` at 0, releases the line.
- R10: When a wrap and `ovf_clr` fall in the same clock, the overflow flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Synchronised bus clock line |
| sda_i | input | 1 | Synchronised bus data line |
| tx_en | input | 1 | Allows the unit to drive the data line |
| data_ld | input | 1 | Load strobe for the data register |
| data_ld_val | input | 8 | Value for the data register |
| cnt_ld | input | 1 | Load strobe for the edge counter |
| cnt_ld_val | input | 4 | Value for the edge counter |
| ovf_clr | input | 1 | Clears the overflow flag |
| data_q | output | 8 | Data register contents |
| cnt_q | output | 4 | Edge counter value |
| ovf_flag | output | 1 | Sticky overflow flag |
| scl_hold | output | 1 | Request to hold the clock line low |
| sda_pull_low | output | 1 | Request to pull the data line low |

## Verification
The bench builds the unit with its default widths of 8 data bits and 4 counter bits. With these widths a complete byte is only sixteen edges long, so one table can step through every intermediate count and register value up to the wrap. The short counter also means the preload-to-14 single-slot case and the wrap-versus-clear collision can be set up in a handful of directed cycles.

// File: rtl/ecs_pkg.sv
package ecs_pkg;
  typedef struct packed {
    logic rise;
    logic fall;
  } scl_edges_t;
endpackage

// File: rtl/scl_edge_detect.sv
module scl_edge_detect
  import ecs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  output scl_edges_t edges_o
);
  logic scl_prev;

  // Idle bus clock is high, so the previous value resets to 1.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) scl_prev <= 1'b1;
    else        scl_prev <= scl_i;
  end

  always_comb begin
    edges_o.rise = scl_i & ~scl_prev;
    edges_o.fall = ~scl_i & scl_prev;
  end
endmodule

// File: rtl/edge_counter.sv
module edge_counter #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_i,
  input  logic             ld_i,
  input  logic [CNT_W-1:0] ld_val_i,
  input  logic             ovf_clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o
);
  localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

  logic wrap;
  assign wrap = step_i && !ld_i && (cnt_o == CNT_TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_o <= '0;
    else if (ld_i)   cnt_o <= ld_val_i;
    else if (step_i) cnt_o <= cnt_o + CNT_W'(1);
  end

  // Setting wins over clearing.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ovf_o <= 1'b0;
    else if (wrap)      ovf_o <= 1'b1;
    else if (ovf_clr_i) ovf_o <= 1'b0;
  end

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !ld_i) |=> (cnt_o == $past(cnt_o) + CNT_W'(1))); // R4
  AST_CNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ld_i |=> (cnt_o == $past(ld_val_i))); // R8
  AST_OVF_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !ld_i && cnt_o == CNT_TOP) |=> (ovf_o && cnt_o == '0)); // R5
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_o && !ovf_clr_i) |=> ovf_o); // R5
  AST_OVF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_clr_i && !(step_i && !ld_i && cnt_o == CNT_TOP)) |=> !ovf_o); // R6
endmodule

// File: rtl/shift_unit.sv
module shift_unit #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_i,
  input  logic              bit_i,
  input  logic              ld_i,
  input  logic [DATA_W-1:0] ld_val_i,
  input  logic              hold_chk_i,
  output logic [DATA_W-1:0] data_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       data_o <= '0;
    else if (ld_i)    data_o <= ld_val_i;
    else if (shift_i) data_o <= {data_o[DATA_W-2:0], bit_i};
  end

  AST_SHIFT_IN: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_i && !ld_i) |=> (data_o == {$past(data_o[DATA_W-2:0]), $past(bit_i)})); // R2
  AST_FALL_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_chk_i && !ld_i) |=> $stable(data_o)); // R3
  AST_DATA_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ld_i |=> (data_o == $past(ld_val_i))); // R7
endmodule

// File: rtl/edge_count_shifter.sv
module edge_count_shifter
  import ecs_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              tx_en,
  input  logic              data_ld,
  input  logic [DATA_W-1:0] data_ld_val,
  input  logic              cnt_ld,
  input  logic [CNT_W-1:0]  cnt_ld_val,
  input  logic              ovf_clr,
  output logic [DATA_W-1:0] data_q,
  output logic [CNT_W-1:0]  cnt_q,
  output logic              ovf_flag,
  output logic              scl_hold,
  output logic              sda_pull_low
);
  localparam int MSB = DATA_W - 1;

  scl_edges_t edges;

  scl_edge_detect u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_i   (scl_i),
    .edges_o (edges)
  );

  edge_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .step_i    (edges.rise | edges.fall),
    .ld_i      (cnt_ld),
    .ld_val_i  (cnt_ld_val),
    .ovf_clr_i (ovf_clr),
    .cnt_o     (cnt_q),
    .ovf_o     (ovf_flag)
  );

  shift_unit #(.DATA_W(DATA_W)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .shift_i    (edges.rise),
    .bit_i      (sda_i),
    .ld_i       (data_ld),
    .ld_val_i   (data_ld_val),
    .hold_chk_i (edges.fall),
    .data_o     (data_q)
  );

  assign scl_hold     = ovf_flag;
  assign sda_pull_low = tx_en & ~data_q[MSB];

  AST_EDGES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({edges.rise, edges.fall})); // R4
  AST_RELEASE_ON_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (data_q[MSB] || !tx_en) |-> !sda_pull_low); // R9
endmodule

// File: tb/edge_count_shifter_tb_top.sv
`timescale 1ns/1ps
module edge_count_shifter_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_i = 1'b1, sda_i = 1'b1, tx_en = 1'b0;
  logic       data_ld = 1'b0, cnt_ld = 1'b0, ovf_clr = 1'b0;
  logic [7:0] data_ld_val = '0;
  logic [3:0] cnt_ld_val = '0;
  logic [7:0] data_q;
  logic [3:0] cnt_q;
  logic       ovf_flag, scl_hold, sda_pull_low;
  int         n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  edge_count_shifter dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i), .tx_en(tx_en),
    .data_ld(data_ld), .data_ld_val(data_ld_val), .cnt_ld(cnt_ld),
    .cnt_ld_val(cnt_ld_val), .ovf_clr(ovf_clr), .data_q(data_q),
    .cnt_q(cnt_q), .ovf_flag(ovf_flag), .scl_hold(scl_hold),
    .sda_pull_low(sda_pull_low)
  );

  // {scl, sda, expected data, expected count, expected overflow}: byte 0xA5
  localparam logic [14:0] VEC [16] = '{
    {1'b0,1'b1,8'h00,4'd1, 1'b0}, {1'b1,1'b1,8'h01,4'd2, 1'b0},
    {1'b0,1'b0,8'h01,4'd3, 1'b0}, {1'b1,1'b0,8'h02,4'd4, 1'b0},
    {1'b0,1'b1,8'h02,4'd5, 1'b0}, {1'b1,1'b1,8'h05,4'd6, 1'b0},
    {1'b0,1'b0,8'h05,4'd7, 1'b0}, {1'b1,1'b0,8'h0A,4'd8, 1'b0},
    {1'b0,1'b0,8'h0A,4'd9, 1'b0}, {1'b1,1'b0,8'h14,4'd10,1'b0},
    {1'b0,1'b1,8'h14,4'd11,1'b0}, {1'b1,1'b1,8'h29,4'd12,1'b0},
    {1'b0,1'b0,8'h29,4'd13,1'b0}, {1'b1,1'b0,8'h52,4'd14,1'b0},
    {1'b0,1'b1,8'h52,4'd15,1'b0}, {1'b1,1'b1,8'hA5,4'd0, 1'b1}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_state(input string req, input logic [7:0] d, input logic [3:0] c, input logic o);
    check(req, {19'd0, data_q, cnt_q, ovf_flag}, {19'd0, d, c, o});
    check({req, " hold"}, {31'd0, scl_hold}, {31'd0, o});
  endtask

  initial begin
    #(200000 * 20);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check_state("R1", 8'h00, 4'd0, 1'b0);
    check("R1 pull", {31'd0, sda_pull_low}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // Table walk: R2 rising shifts, R3 falling keeps, R4 counting, R5 wrap
    for (int i = 0; i < 16; i++) begin
      scl_i = VEC[i][14];
      sda_i = VEC[i][13];
      @(negedge clk);
      check_state(VEC[i][14] ? "R2/R4/R5" : "R3/R4", VEC[i][12:5], VEC[i][4:1], VEC[i][0]);
    end

    // R5: flag sticky with no edges
    repeat (4) @(negedge clk);
    check_state("R5 sticky", 8'hA5, 4'd0, 1'b1);

    // R6: clear releases hold
    ovf_clr = 1'b1; @(negedge clk); ovf_clr = 1'b0;
    check_state("R6", 8'hA5, 4'd0, 1'b0);

    // R9: drive gating
    tx_en = 1'b1; #1;
    check("R9 msb1", {31'd0, sda_pull_low}, 32'd0);
    data_ld = 1'b1; data_ld_val = 8'h25; @(negedge clk); data_ld = 1'b0;
    check("R7 load", {24'd0, data_q}, 32'h25);
    check("R9 msb0", {31'd0, sda_pull_low}, 32'd1);
    tx_en = 1'b0; #1;
    check("R9 txoff", {31'd0, sda_pull_low}, 32'd0);

    // R7: load wins over a rising-edge shift (scl currently 1)
    scl_i = 1'b0; @(negedge clk);            // fall: count 0 -> 1, data kept
    scl_i = 1'b1; sda_i = 1'b1; data_ld = 1'b1; data_ld_val = 8'h3C;
    @(negedge clk); data_ld = 1'b0;
    check("R7 prio", {24'd0, data_q}, 32'h3C);

    // R8: preload 14, one fall -> 15, one rise -> 0 with overflow
    cnt_ld = 1'b1; cnt_ld_val = 4'd14; @(negedge clk); cnt_ld = 1'b0;
    check("R8 load", {28'd0, cnt_q}, 32'd14);
    scl_i = 1'b0; @(negedge clk);
    check_state("R8 fall", 8'h3C, 4'd15, 1'b0);
    scl_i = 1'b1; sda_i = 1'b0; @(negedge clk);
    check_state("R8 rise", 8'h78, 4'd0, 1'b1);

    // R8: load wins over counting in the same clock
    scl_i = 1'b0; cnt_ld = 1'b1; cnt_ld_val = 4'd15; @(negedge clk); cnt_ld = 1'b0;
    check("R8 prio", {28'd0, cnt_q}, 32'd15);

    // R10: wrap and clear together leave the flag set
    scl_i = 1'b1; ovf_clr = 1'b1; @(negedge clk); ovf_clr = 1'b0;
    check_state("R10", 8'hF0, 4'd0, 1'b1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule